// File: doc/BRIEF.md
# Crosspoint Routing Configuration Register

This block stores the routing setup of a crosspoint with 16 outputs and 16 inputs. Each output owns a 5-bit slot made of an enable flag and a 4-bit input number. The slots sit in a first rank that can be filled two ways. In serial mode, bits enter one at a time on the falling edge of an external shift clock, forming an 80-bit chain. In parallel mode, an address picks one slot, and that slot is written from five data lines for as long as the shift clock is low. A serial output taps the far end of the chain, so several blocks can be daisy-chained.

A second rank drives the matrix controls, one enable and one 4-bit select per output. It copies the first rank for as long as both the update strobe and the chip-enable input are low, and holds its value otherwise. The configuration can therefore be staged out of sight and applied at once. An active-low asynchronous reset clears the second rank, which disables every output, and leaves the first rank as it was.

All storage is clocked by a fast system clock. The external shift clock, update, chip enable, mode, data and address pins pass through a synchroniser of equal depth, and edge and level detection on the synchronised copies produce the load strobes.

Top module: `xpt_cfg_reg`

## Requirements
- R1: After 80 serial bits, output n takes the five bits shifted at positions 5*(15-n) to 5*(15-n)+4, counted from 0. The first of these five is the enable and the next four are the select, most significant bit first. The slot for output 15 is therefore shifted first and the slot for output 0 last.
- R2: A serial bit is captured only on a falling edge of the shift clock. The value of the serial input when the clock rises again has no effect.
- R3: `serOut` always shows the most significant first-rank bit, which is the enable of output 15's slot. A bit shifted in appears there after 80 falling edges. The tap keeps following the first rank in parallel mode.
- R4: While `chipEnN` is high, shift edges, parallel writes and update strobes change neither rank.
- R5: In parallel mode (`parMode`=1), a low shift clock writes `parData` into the slot chosen by `parAddr`. `parData` bit 4 is the enable and bits 3:0 are the select. Every other slot keeps its contents.
- R6: The second rank follows the first rank while `updateN` and `chipEnN` are both low, including through shifts made in that state. It holds its value otherwise.
- R7: While `resetN` is low, every output is disabled and all selects read zero. The first rank is left untouched, so an update after reset restores the staged setup.
- R8: An output whose enable is low drives a select of zero, whatever its stored select bits hold.
- R9: In parallel mode, falling shift-clock edges do not shift the chain. In serial mode (`parMode`=0), a low shift clock does not write a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock for all storage |
| resetN | input | 1 | Asynchronous active-low reset of the second rank |
| chipEnN | input | 1 | Active-low chip enable |
| updateN | input | 1 | Active-low transfer strobe into the second rank |
| shiftClk | input | 1 | External shift / write clock |
| parMode | input | 1 | 1 = parallel slot write, 0 = serial shift |
| serIn | input | 1 | Serial data in |
| parAddr | input | 4 | Slot address for a parallel write |
| parData | input | 5 | Parallel slot data: bit 4 enable, bits 3:0 select |
| serOut | output | 1 | Most significant first-rank bit, for daisy chaining |
| outEn | output | 16 | Per-output enable from the second rank |
| outSel | output | 64 | Packed input selects; output n uses bits 4n+3:4n |

## Verification
The bench loads full patterns, reads back every output, and checks each slot's position. A reversed chain or misplaced enable would scramble the slots. It swaps the serial input between the falling and rising clock edges, which would expose a design that captures on the wrong edge. It counts the 80-bit delay to the serial tap and watches that tap follow parallel writes, which catches an off-by-one chain or a tap that is gated by mode. It also stages writes while update is high, asserts reset, and then updates again. A design that leaked staged data, wiped the first rank on reset, or let chip enable high or the wrong mode alter a rank would return a setup that differs from the expected one.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int NUM_OUT     = 16;
  localparam int SEL_W       = 4;
  localparam int SLOT_W      = SEL_W + 1;
  localparam int RANK_W      = NUM_OUT * SLOT_W;
  localparam int ADDR_W      = $clog2(NUM_OUT);
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic              shiftEn;
    logic              shiftBit;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [SLOT_W-1:0] wrData;
    logic              xferEn;
  } cfgStrobe_t;
endpackage

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_cfg_pkg::*;
#(
  parameter int SyncStages = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              chipEnN,
  input  logic              updateN,
  input  logic              shiftClk,
  input  logic              parMode,
  input  logic              serIn,
  input  logic [ADDR_W-1:0] parAddr,
  input  logic [SLOT_W-1:0] parData,
  output cfgStrobe_t        strb
);
  localparam int PinW = 5 + ADDR_W + SLOT_W;
  localparam logic [PinW-1:0] IdleVec = {3'b111, {(PinW-3){1'b0}}};

  logic [PinW-1:0] pinVec;
  logic [PinW-1:0] stageQ [SyncStages];
  logic [PinW-1:0] syncd;
  logic            clkPrev;

  assign pinVec = {chipEnN, updateN, shiftClk, parMode, serIn, parAddr, parData};

  // equal-depth synchroniser keeps data aligned with its strobes
  for (genvar s = 0; s < SyncStages; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge resetN)
        if (!resetN) stageQ[s] <= IdleVec;
        else         stageQ[s] <= pinVec;
    end else begin : g_next
      always_ff @(posedge clk or negedge resetN)
        if (!resetN) stageQ[s] <= IdleVec;
        else         stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncd = stageQ[SyncStages-1];

  logic              sCeN, sUpdN, sClk, sPar, sSer;
  logic [ADDR_W-1:0] sAddr;
  logic [SLOT_W-1:0] sData;
  assign {sCeN, sUpdN, sClk, sPar, sSer, sAddr, sData} = syncd;

  always_ff @(posedge clk or negedge resetN)
    if (!resetN) clkPrev <= 1'b1;
    else         clkPrev <= sClk;

  always_comb begin
    strb.shiftEn  = !sCeN && !sPar && clkPrev && !sClk;
    strb.shiftBit = sSer;
    strb.wrEn     = !sCeN && sPar && !sClk;
    strb.wrAddr   = sAddr;
    strb.wrData   = sData;
    strb.xferEn   = !sCeN && !sUpdN;
  end

  // R2: one falling edge yields exactly one shift
  a_r2_single_shift: assert property (@(posedge clk) disable iff (!resetN)
    strb.shiftEn |=> !strb.shiftEn);
endmodule

// File: rtl/xpt_cfg_dp.sv
module xpt_cfg_dp
  import xpt_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     resetN,
  input  cfgStrobe_t               strb,
  output logic                     serOut,
  output logic [NUM_OUT-1:0]       outEn,
  output logic [NUM_OUT*SEL_W-1:0] outSel
);
  logic [RANK_W-1:0] firstRank;
  logic [RANK_W-1:0] secondRank;
  logic [RANK_W-1:0] wrMask;

  assign wrMask = {{(RANK_W-SLOT_W){1'b0}}, {SLOT_W{1'b1}}} << (strb.wrAddr * SLOT_W);

  // first rank: not touched by reset
  always_ff @(posedge clk) begin
    if (strb.shiftEn)
      firstRank <= {firstRank[RANK_W-2:0], strb.shiftBit};
    else if (strb.wrEn)
      firstRank[strb.wrAddr*SLOT_W +: SLOT_W] <= strb.wrData;
  end

  always_ff @(posedge clk or negedge resetN)
    if (!resetN)          secondRank <= '0;
    else if (strb.xferEn) secondRank <= firstRank;

  assign serOut = firstRank[RANK_W-1];

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    assign outEn[n] = secondRank[n*SLOT_W + SEL_W];
    assign outSel[n*SEL_W +: SEL_W] =
      secondRank[n*SLOT_W + SEL_W] ? secondRank[n*SLOT_W +: SEL_W] : '0;
  end

  // R1: a shift moves the chain up by one and inserts the new bit
  a_r1_shift_moves: assert property (@(posedge clk) disable iff (!resetN)
    strb.shiftEn |=> firstRank == {$past(firstRank[RANK_W-2:0]), $past(strb.shiftBit)});

  // R5: a parallel write leaves all other slots alone
  a_r5_slot_isolated: assert property (@(posedge clk) disable iff (!resetN)
    strb.wrEn |=> ((firstRank ^ $past(firstRank)) & ~$past(wrMask)) == '0);

  // R6: without a transfer strobe the second rank holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!resetN)
    !strb.xferEn |=> $stable(secondRank));

  // R7: during reset every output is disabled
  always @(posedge clk)
    if (!resetN) a_r7_reset_off: assert (outEn == '0 && outSel == '0);
endmodule

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg
  import xpt_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     resetN,
  input  logic                     chipEnN,
  input  logic                     updateN,
  input  logic                     shiftClk,
  input  logic                     parMode,
  input  logic                     serIn,
  input  logic [ADDR_W-1:0]        parAddr,
  input  logic [SLOT_W-1:0]        parData,
  output logic                     serOut,
  output logic [NUM_OUT-1:0]       outEn,
  output logic [NUM_OUT*SEL_W-1:0] outSel
);
  cfgStrobe_t strb;

  xpt_cfg_ctrl #(.SyncStages(SYNC_STAGES)) u_ctrl (
    .clk(clk), .resetN(resetN), .chipEnN(chipEnN), .updateN(updateN),
    .shiftClk(shiftClk), .parMode(parMode), .serIn(serIn),
    .parAddr(parAddr), .parData(parData), .strb(strb)
  );

  xpt_cfg_dp u_dp (
    .clk(clk), .resetN(resetN), .strb(strb),
    .serOut(serOut), .outEn(outEn), .outSel(outSel)
  );
endmodule

// File: tb/xpt_cfg_reg_tb.sv
module xpt_cfg_reg_tb;
  logic        clk = 1'b0;
  logic        resetN = 1'b0;
  logic        chipEnN = 1'b0;
  logic        updateN = 1'b1;
  logic        shiftClk = 1'b1;
  logic        parMode = 1'b0;
  logic        serIn = 1'b0;
  logic [3:0]  parAddr = '0;
  logic [4:0]  parData = '0;
  logic        serOut;
  logic [15:0] outEn;
  logic [63:0] outSel;

  always #4 clk = ~clk;

  xpt_cfg_reg u_dut (.*);

  typedef struct {
    string       tag;
    logic [15:0] en;
    logic [63:0] sel;
    logic        so;
    bit          chkSo;
  } sbItem_t;

  sbItem_t sbQ[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  bit [79:0] r1 = '0;
  bit [79:0] r2 = '0;
  bit [4:0] cfgA [16];

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic syncR2();
    if (!chipEnN && !updateN) r2 = r1;
  endtask

  // R2: data swapped before the rising edge must not matter
  task automatic shiftBit(bit b);
    serIn = b; tick(2);
    shiftClk = 1'b0; tick(5);
    serIn = ~b; tick(2);
    shiftClk = 1'b1; tick(4);
    if (!chipEnN && !parMode) r1 = {r1[78:0], b};
    syncR2();
  endtask

  task automatic parWrite(bit [3:0] a, bit [4:0] d);
    parAddr = a; parData = d; tick(2);
    shiftClk = 1'b0; tick(5);
    shiftClk = 1'b1; tick(4);
    if (!chipEnN && parMode) r1[a*5 +: 5] = d;
    syncR2();
  endtask

  task automatic pulseUpdate();
    updateN = 1'b0; tick(5);
    syncR2();
    updateN = 1'b1; tick(4);
  endtask

  task automatic loadCfg(bit [4:0] c [16]);
    for (int o = 15; o >= 0; o--)
      for (int k = 4; k >= 0; k--) shiftBit(c[o][k]);
  endtask

  task automatic expectNow(string tag, bit chkSo);
    sbItem_t it;
    it.tag = tag; it.chkSo = chkSo; it.so = r1[79];
    for (int n = 0; n < 16; n++) begin
      it.en[n] = r2[n*5+4];
      it.sel[n*4 +: 4] = r2[n*5+4] ? r2[n*5 +: 4] : 4'h0;
    end
    sbQ.push_back(it);
    tick(1);
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      sbItem_t it;
      it = sbQ.pop_front();
      total++;
      if (outEn !== it.en || outSel !== it.sel || (it.chkSo && serOut !== it.so)) begin
        bad++;
        $display("FAIL %s: en=%h sel=%h so=%b expected en=%h sel=%h so=%b",
                 it.tag, outEn, outSel, serOut, it.en, it.sel, it.so);
      end
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      finishRun();
    end
  end

  initial begin
    for (int o = 0; o < 16; o++)
      cfgA[o] = {(o % 3 != 0), 4'((o * 7 + 3) & 15)};
    tick(3);
    expectNow("R7 reset state outputs disabled", 0);
    resetN = 1'b1; tick(3);

    // R1 full load, staged while update high (R6 hold)
    loadCfg(cfgA);
    expectNow("R6 staged load not visible", 1);
    pulseUpdate();
    expectNow("R1 slot order and bit order after full load", 1);
    expectNow("R8 disabled outputs select zero", 1);

    // R3: 80-clock delay to the serial tap
    begin
      bit [4:0] z [16];
      for (int o = 0; o < 16; o++) z[o] = 5'h0;
      loadCfg(z);
    end
    shiftBit(1'b1);
    for (int i = 0; i < 78; i++) shiftBit(1'b0);
    expectNow("R3 marker not yet at tap after 79 edges", 1);
    shiftBit(1'b0);
    expectNow("R3 marker at tap after 80 edges", 1);
    pulseUpdate();
    expectNow("R2 captured value is the falling-edge value", 1);

    // R5 parallel write while update high; R3 tap live in parallel mode
    parMode = 1'b1;
    parWrite(4'd5, 5'b1_1010);
    expectNow("R6 parallel write staged only", 1);
    pulseUpdate();
    expectNow("R5 single slot written, others kept", 1);
    parWrite(4'd15, 5'b0_0110);
    expectNow("R3 tap follows first rank in parallel mode", 1);

    // R9 parallel mode: falling edges do not shift
    shiftBit(1'b1);
    pulseUpdate();
    expectNow("R9 no shift in parallel mode", 1);

    // R9 serial mode: low clock does not write a slot
    parMode = 1'b0;
    parAddr = 4'd3; parData = 5'b11111;
    shiftBit(1'b0);
    pulseUpdate();
    expectNow("R9 no slot write in serial mode", 1);

    // R4: chip enable high blocks both ranks
    chipEnN = 1'b1;
    for (int i = 0; i < 5; i++) shiftBit(1'b1);
    parMode = 1'b1; parWrite(4'd0, 5'b1_1111); parMode = 1'b0;
    pulseUpdate();
    expectNow("R4 chip enable high changes nothing", 1);
    chipEnN = 1'b0; tick(3);

    // R7: reset clears second rank only
    loadCfg(cfgA);
    pulseUpdate();
    expectNow("R1 reload before reset", 1);
    resetN = 1'b0; r2 = '0; tick(3);
    expectNow("R7 outputs disabled during reset, tap kept", 1);
    resetN = 1'b1; tick(3);
    pulseUpdate();
    expectNow("R7 first rank retained across reset", 1);

    // R6 transparent: outputs follow shifts while update low
    updateN = 1'b0; tick(5); syncR2();
    for (int i = 0; i < 7; i++) shiftBit(i[0]);
    expectNow("R6 second rank transparent while update low", 1);
    updateN = 1'b1; tick(4);
    shiftBit(1'b1);
    expectNow("R6 second rank holds after update rises", 1);

    tick(4);
    done = 1;
    finishRun();
  end
endmodule